// File: doc/BRIEF.md
# Deferred-Compare Duplicated Increment Stage

This block is one slice of a self-checking datapath that a one-hot controller steers. It has two load enables. In the compute step, two identical increment operators work on the same operand. Each result lands in its own register. The functional copy drives the block's result output.

In the check step, which comes one clock later, a comparator reads the two registers. Any disagreement sets a sticky fault flag. Because the check is deferred, a fault is reported one cycle late. In return, the check enable also tests the controller. If that enable fires before the compute step has loaded both registers, the comparator sees contents that are not related, and it flags the fault.

The two registers reset to different values: all zeros for the functional copy and all ones for the duplicate. This makes a premature check straight after reset always visible. The chance that a stale pair matches by accident shrinks as 2^-WIDTH. The default width of 8 sits above the 7-bit floor at which the check step is treated as secure.

Top module: `dcc_stage`

## Requirements
- R1: While reset (active low) is asserted, `result_o` is 0 and `fault_o` is 0.
- R2: When `ld_compute_i` is high at a rising edge, `result_o` shows `operand_i + 1` from that edge on.
- R3: When `ld_compute_i` is low at a rising edge, `result_o` keeps its value.
- R4: The increment wraps, so an all-ones operand gives a result of 0.
- R5: When `ld_check_i` is high at a rising edge and both result registers are equal, `fault_o` stays 0.
- R6: When `ld_check_i` is high at a rising edge and the two registers differ, `fault_o` is 1 from that edge on.
- R7: Once `fault_o` is 1, it stays 1 until reset, whatever the inputs do.
- R8: When `ld_check_i` is low, a difference between the registers does not change `fault_o`.
- R9: Reset loads the functional register with all zeros and the duplicate register with all ones. A check step with no compute step since reset therefore raises `fault_o` (0 vs 255 at the default width).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| operand_i | input | WIDTH | Operand fed to both increment copies |
| ld_compute_i | input | 1 | One-hot enable of the compute step; loads both result registers |
| ld_check_i | input | 1 | One-hot enable of the check step; samples the comparator |
| result_o | output | WIDTH | Functional result register |
| fault_o | output | 1 | Sticky mismatch flag |

## Verification
The result is due one edge after the compute enable is sampled. The fault flag is due one edge after the check enable is sampled, so a fault takes two edges from the operand load to the flag. The bench drives every input on a falling edge and reads both outputs on the next falling edge, which is the first point where the updated registers are settled. A model in the bench tracks the expected functional and duplicate register values from the requirements. Against this model it checks random compute, check and idle sequences, operand wrap, a premature check straight after reset, and the stickiness of the flag.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  // default datapath width of the stage
  localparam int unsigned DCC_DEF_WIDTH = 8;
  // number of redundant operator lanes (functional + duplicate)
  localparam int unsigned DCC_LANES = 2;
  // widths below this floor give too high a chance of a stale match
  localparam int unsigned DCC_SECURE_MIN_WIDTH = 7;
endpackage

// File: rtl/dcc_incr.sv
module dcc_incr #(
  parameter int unsigned WIDTH = dcc_pkg::DCC_DEF_WIDTH
) (
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] y_o
);
  always_comb begin
    y_o = a_i + WIDTH'(1);
  end
endmodule

// File: rtl/dcc_lane_reg.sv
module dcc_lane_reg #(
  parameter int unsigned     WIDTH   = dcc_pkg::DCC_DEF_WIDTH,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;
  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = ld_i ? d_i : q_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_VAL;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  // R2
  lane_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (q_o == $past(d_i)));

  // R3
  lane_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o));
endmodule

// File: rtl/dcc_cmp_latch.sv
module dcc_cmp_latch #(
  parameter int unsigned WIDTH = dcc_pkg::DCC_DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ck_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             fault_o
);
  logic mismatch;
  logic fault_q;
  logic fault_d;

  always_comb begin
    mismatch = (a_i != b_i);
    fault_d  = fault_q | (ck_i & mismatch);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= fault_d;
  end

  assign fault_o = fault_q;

  // R6
  cmp_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ck_i && (a_i != b_i)) |=> fault_o);

  // R5
  cmp_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ck_i && !fault_o && (a_i == b_i)) |=> !fault_o);

  // R7
  cmp_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o);

  // R8
  cmp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ck_i && !fault_o) |=> !fault_o);
endmodule

// File: rtl/dcc_stage.sv
module dcc_stage #(
  parameter int unsigned WIDTH = dcc_pkg::DCC_DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] operand_i,
  input  logic             ld_compute_i,
  input  logic             ld_check_i,
  output logic [WIDTH-1:0] result_o,
  output logic             fault_o
);
  localparam int unsigned LANES = dcc_pkg::DCC_LANES;

  logic [WIDTH-1:0] sum_w [LANES];
  logic [WIDTH-1:0] reg_q [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // lane 0 resets to zeros, lane 1 to ones, so a premature check mismatches
    localparam logic [WIDTH-1:0] LANE_RST = (l == 0) ? '0 : '1;

    dcc_incr #(.WIDTH(WIDTH)) u_incr (
      .a_i (operand_i),
      .y_o (sum_w[l])
    );

    dcc_lane_reg #(.WIDTH(WIDTH), .RST_VAL(LANE_RST)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_i   (ld_compute_i),
      .d_i    (sum_w[l]),
      .q_o    (reg_q[l])
    );
  end

  dcc_cmp_latch #(.WIDTH(WIDTH)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ck_i    (ld_check_i),
    .a_i     (reg_q[0]),
    .b_i     (reg_q[1]),
    .fault_o (fault_o)
  );

  assign result_o = reg_q[0];

  // R1
  rst_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (result_o == '0 && !fault_o));

  // R4
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_compute_i && operand_i == '1) |=> (result_o == '0));
endmodule

// File: tb/dcc_stage_test.sv
module dcc_stage_test;
  localparam int W = 8;
  localparam logic [W-1:0] ONES = '1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] operand_i = '0;
  logic         ld_compute_i = 1'b0;
  logic         ld_check_i = 1'b0;
  logic [W-1:0] result_o;
  logic         fault_o;

  int n_tests = 0;
  int n_fail = 0;

  logic [W-1:0] m_func, m_dup;
  logic         m_fault;

  always #2.5 clk_i = ~clk_i;

  dcc_stage #(.WIDTH(W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .operand_i(operand_i),
    .ld_compute_i(ld_compute_i), .ld_check_i(ld_check_i),
    .result_o(result_o), .fault_o(fault_o)
  );

  function automatic logic [W-1:0] inc_ref(input logic [W-1:0] x);
    return x + 8'd1;
  endfunction

  task automatic check_out(input string req);
    n_tests++;
    if (result_o !== m_func) begin
      n_fail++;
      $display("FAIL %s result actual=%0d expected=%0d", req, result_o, m_func);
    end
    n_tests++;
    if (fault_o !== m_fault) begin
      n_fail++;
      $display("FAIL %s fault actual=%0d expected=%0d", req, fault_o, m_fault);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; ld_compute_i = 1'b0; ld_check_i = 1'b0;
    m_func = '0; m_dup = ONES; m_fault = 1'b0;
    @(negedge clk_i);
    check_out("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // inputs driven at a falling edge, outputs read at the next falling edge
  task automatic step(input logic cmp, input logic ck, input logic [W-1:0] op,
                      input string req);
    ld_compute_i = cmp; ld_check_i = ck; operand_i = op;
    if (ck && (m_func != m_dup)) m_fault = 1'b1;
    if (cmp) begin m_func = inc_ref(op); m_dup = inc_ref(op); end
    @(negedge clk_i);
    check_out(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    do_reset();
    // R8: registers differ after reset, no check -> no fault
    step(1'b0, 1'b0, 8'd5, "R8");
    step(1'b0, 1'b0, 8'd9, "R8_R3");
    // R9 / R6: premature check right after reset
    step(1'b0, 1'b1, 8'd0, "R9_R6");
    // R7: clean compute/check pairs do not clear the flag
    step(1'b1, 1'b0, 8'd40, "R7");
    step(1'b0, 1'b1, 8'd40, "R7");
    step(1'b0, 1'b0, 8'd0, "R7");
    do_reset();
    // R4: wrap
    step(1'b1, 1'b0, ONES, "R4");
    step(1'b0, 1'b1, 8'd0, "R4_R5");
    // compute and check in the same cycle: compares earlier equal contents
    step(1'b1, 1'b1, 8'd77, "R2_R5");
    step(1'b0, 1'b1, 8'd3, "R5");
    // random well-formed sequences
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] op;
      int gap;
      op = W'($urandom);
      step(1'b1, 1'b0, op, "R2");
      gap = int'($urandom % 3);
      for (int j = 0; j < gap; j++) step(1'b0, 1'b0, W'($urandom), "R3");
      step(1'b0, 1'b1, W'($urandom), "R5");
    end
    do_reset();
    step(1'b0, 1'b0, 8'd1, "R1_R8");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule